// File: doc/BRIEF.md
# Late-Write Synchronous SRAM With Zero Turnaround

This block is a synchronous static memory. A read and a write can follow each other on every clock, with no idle cycle between them. Write data reaches the block a fixed number of edges after its command, and that delay equals the read latency. The data bus therefore carries one transfer per cycle in either direction.

The array holds 256 words by default. Each word has four lanes of nine bits. The block samples every command, address and lane-enable input on the rising clock edge. It has separate buses for data in and data out, and a `dout_en` flag stands for the tri-state driver. A static mode input selects one of two timings:
- **Registered output:** reads take two edges and writes take three edges.
- **Flow-through:** both paths are one edge shorter.

Burst address stepping and sleep sequencing are done outside the block. Their results arrive on `addr_cont` and `sleep`.

Top module: `lw_sram`

## Requirements
- R1: A command is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If any one of these is inactive on a load cycle, the cycle is a deselect. It writes no memory and produces no read output.
- R2: When `load_n`=0 a new command starts at `addr_ext`. `wr_n`=1 selects a read and `wr_n`=0 selects a write.
- R3: The lane enables are active low. `lanes_n[i]` controls data bits [9i+8:9i], and lanes not enabled keep their stored value. A write with all enables high is an abort and leaves the memory unchanged.
- R4: With `flow_mode`=0, a read sampled at edge k drives `dout` from edge k+1 until edge k+2.
- R5: With `flow_mode`=0, the data for a write sampled at edge k is taken from `din` at edge k+2.
- R6: With `flow_mode`=1, a read sampled at edge k drives `dout` from edge k until edge k+1. The data for a write sampled at edge k is taken from `din` at edge k+1.
- R7: While `clk_en_n`=1, every edge is ignored:
  - internal state is frozen;
  - a read that is driving keeps driving the same data;
  - a pending write keeps the outputs off;
  - `din` is not sampled.
- R8: During write cycles `dout_en` stays 0 whatever the value of `oe_n`. `oe_n`=1 turns the outputs off at once, without waiting for a clock edge, so a read issued with it high is a dummy read.
- R9: With `load_n`=1 the block repeats the type of the last loaded command at `addr_cont`, using the current lane enables and ignoring `wr_n` and the selects. When the last load was a deselect, a continue cycle is also a deselect.
- R10: A read of an address whose write is still waiting for its data returns that write's data, merged by lane over the older contents.
- R11: While reset is asserted, `dout_en`=0 and `dout`=0.
- R12: `sleep`=1 turns the outputs off at once, and any command sampled while it is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = registered-output timing (static) |
| clk_en_n | input | 1 | Edge enable, active low; high stalls the block |
| sleep | input | 1 | From sleep sequencer; blocks commands and outputs |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| load_n | input | 1 | 0 = load a new command, 1 = continue the last one |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| lanes_n | input | 4 | Per-lane write enables, active low |
| addr_ext | input | 8 | Address for load cycles |
| addr_cont | input | 8 | Address for continue cycles, from burst generator |
| din | input | 36 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Models the output driver being on |

## Verification
The bench drives inputs on the falling edge and reads outputs at the next falling edge. A result that a register sets at edge k is therefore seen in the half cycle that follows that edge.

In registered-output mode:
- A read is checked off one sample after its command, on the next sample and off again on the one after.
- Write data is driven two samples after its command, so that it is present at the second edge after the command.

In flow-through mode:
- A read is checked on the very next sample.
- Write data is driven one sample after its command.

Stall, sleep and output-enable checks look at the output during the cycles the stimulus covers. The asynchronous cases are sampled one time step after the input changes.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  localparam int LANE_BITS = 9;
  localparam int NUM_LANES = 4;
  localparam int WORD_BITS = LANE_BITS * NUM_LANES;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [NUM_LANES-1:0] lane_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Replace every lane whose active-low enable is 0 with the update word.
  function automatic word_t merge_lanes(word_t base, word_t upd, lane_t en_n);
    word_t res;
    res = base;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (!en_n[i]) res[i*LANE_BITS +: LANE_BITS] = upd[i*LANE_BITS +: LANE_BITS];
    end
    return res;
  endfunction

  // Decode one cycle: continue repeats the held type, load checks selects.
  function automatic op_e pick_op(op_e held, logic load_n, logic chosen, logic wr_n);
    if (load_n)  return held;
    if (!chosen) return OP_NONE;
    return wr_n ? OP_RD : OP_WR;
  endfunction

endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 sleep,
  input  logic                 load_n,
  input  logic                 sel_a_n,
  input  logic                 sel_b,
  input  logic                 sel_c_n,
  input  logic                 wr_n,
  input  lane_t                lanes_n,
  input  logic [ADDR_BITS-1:0] addr_ext,
  input  logic [ADDR_BITS-1:0] addr_cont,
  output op_e                  op1,
  output logic [ADDR_BITS-1:0] addr1,
  output lane_t                lanes1
);

  op_e                  held;
  logic                 chosen;
  op_e                  cmd_op;
  logic [ADDR_BITS-1:0] cmd_addr;

  assign chosen   = !sel_a_n && sel_b && !sel_c_n;
  assign cmd_op   = pick_op(held, load_n, chosen, wr_n);
  assign cmd_addr = load_n ? addr_cont : addr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1    <= OP_NONE;
      held   <= OP_NONE;
      addr1  <= '0;
      lanes1 <= '1;
    end else if (adv) begin
      op1    <= sleep ? OP_NONE : cmd_op;
      addr1  <= cmd_addr;
      lanes1 <= lanes_n;
      if (!sleep && !load_n) held <= cmd_op;
    end
  end

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sleep && !load_n && !chosen) |=> (op1 == OP_NONE));

  p_cont_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sleep && load_n && held == OP_NONE) |=> (op1 == OP_NONE));

  p_sleep_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sleep) |=> (op1 == OP_NONE));

endmodule

// File: rtl/lw_sram_late.sv
module lw_sram_late
  import lw_sram_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 flow,
  input  op_e                  op1,
  input  logic [ADDR_BITS-1:0] addr1,
  input  lane_t                lanes1,
  output logic                 commit_en,
  output logic [ADDR_BITS-1:0] commit_addr,
  output lane_t                commit_lanes_n,
  output lane_t                fwd_lanes_n
);

  op_e                  op2;
  logic [ADDR_BITS-1:0] addr2;
  lane_t                lanes2;
  logic                 src_wr;

  // Second stage is only used by the registered-output timing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op2    <= OP_NONE;
      addr2  <= '0;
      lanes2 <= '1;
    end else if (adv) begin
      op2    <= flow ? OP_NONE : op1;
      addr2  <= addr1;
      lanes2 <= lanes1;
    end
  end

  assign src_wr         = flow ? (op1 == OP_WR) : (op2 == OP_WR);
  assign commit_addr    = flow ? addr1 : addr2;
  assign commit_lanes_n = flow ? lanes1 : lanes2;
  assign commit_en      = adv && src_wr && (commit_lanes_n != '1);
  assign fwd_lanes_n    = (commit_en && commit_addr == addr1) ? commit_lanes_n : '1;

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(op2) && $stable(addr2) && $stable(lanes2)));

  p_late_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flow && op1 == OP_WR) |=> (op2 == OP_WR));

endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] waddr,
  input  lane_t                wlanes_n,
  input  word_t                wdata,
  input  logic [ADDR_BITS-1:0] raddr,
  output word_t                rdata
);

  localparam int DEPTH = 1 << ADDR_BITS;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_bank
    logic [LANE_BITS-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wlanes_n[g]) bank[waddr] <= wdata[g*LANE_BITS +: LANE_BITS];
    end

    assign rdata[g*LANE_BITS +: LANE_BITS] = bank[raddr];
  end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flow_mode,
  input  logic                 clk_en_n,
  input  logic                 sleep,
  input  logic                 sel_a_n,
  input  logic                 sel_b,
  input  logic                 sel_c_n,
  input  logic                 load_n,
  input  logic                 wr_n,
  input  logic [NUM_LANES-1:0] lanes_n,
  input  logic [ADDR_BITS-1:0] addr_ext,
  input  logic [ADDR_BITS-1:0] addr_cont,
  input  logic [WORD_BITS-1:0] din,
  input  logic                 oe_n,
  output logic [WORD_BITS-1:0] dout,
  output logic                 dout_en
);

  logic                 adv;
  op_e                  op1;
  logic [ADDR_BITS-1:0] addr1;
  lane_t                lanes1;
  logic                 commit_en;
  logic [ADDR_BITS-1:0] commit_addr;
  lane_t                commit_lanes_n;
  lane_t                fwd_lanes_n;
  word_t                core_rdata;
  logic                 rd_q_valid;
  word_t                rd_q_data;
  logic                 out_valid;
  word_t                out_data;

  assign adv = !clk_en_n;

  lw_sram_cmd #(.ADDR_BITS(ADDR_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sleep(sleep), .load_n(load_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .lanes_n(lanes_n), .addr_ext(addr_ext), .addr_cont(addr_cont),
    .op1(op1), .addr1(addr1), .lanes1(lanes1)
  );

  lw_sram_late #(.ADDR_BITS(ADDR_BITS)) u_late (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flow(flow_mode),
    .op1(op1), .addr1(addr1), .lanes1(lanes1),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_lanes_n(commit_lanes_n), .fwd_lanes_n(fwd_lanes_n)
  );

  lw_sram_core #(.ADDR_BITS(ADDR_BITS)) u_core (
    .clk(clk), .we(commit_en), .waddr(commit_addr), .wlanes_n(commit_lanes_n),
    .wdata(din), .raddr(addr1), .rdata(core_rdata)
  );

  // Output register: a read leaving stage one picks up any write landing now.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q_valid <= 1'b0;
      rd_q_data  <= '0;
    end else if (adv) begin
      rd_q_valid <= (op1 == OP_RD) && !flow_mode;
      rd_q_data  <= merge_lanes(core_rdata, din, fwd_lanes_n);
    end
  end

  assign out_valid = flow_mode ? (op1 == OP_RD) : rd_q_valid;
  assign out_data  = flow_mode ? core_rdata : rd_q_data;
  assign dout_en   = out_valid && !oe_n && !sleep;
  assign dout      = dout_en ? out_data : '0;

  p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flow_mode && op1 == OP_RD) |=> rd_q_valid);

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && op1 == OP_WR) |=> !rd_q_valid);

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(rd_q_valid) && $stable(rd_q_data)));

endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;

  localparam logic [35:0] D1   = 36'h123456789;
  localparam logic [35:0] D2   = 36'h2468ACE13;
  localparam logic [35:0] D3   = 36'h0F1E2D3C4;
  localparam logic [35:0] D4   = 36'h3C3C3C3C3;
  localparam logic [35:0] D5   = 36'h55AA55AA5;
  localparam logic [35:0] D6   = 36'h987654321;
  localparam logic [35:0] D7   = 36'h0000FFFF1;
  localparam logic [35:0] DA   = 36'h111111111;
  localparam logic [35:0] DB   = 36'h222222222;
  localparam logic [35:0] JUNK = 36'hFFFFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n, flow_mode, clk_en_n, sleep, sel_a_n, sel_b, sel_c_n;
  logic        load_n, wr_n, oe_n, dout_en;
  logic [3:0]  lanes_n;
  logic [7:0]  addr_ext, addr_cont;
  logic [35:0] din, dout;
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lw_sram uut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .clk_en_n(clk_en_n),
    .sleep(sleep), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .load_n(load_n), .wr_n(wr_n), .lanes_n(lanes_n), .addr_ext(addr_ext),
    .addr_cont(addr_cont), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [35:0] exp_merge(logic [35:0] old, logic [35:0] nw, logic [3:0] en_n);
    logic [35:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) if (!en_n[k]) m[k*9 +: 9] = 9'h1FF;
    return (old & ~m) | (nw & m);
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic nop();
    load_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = 1'b1; lanes_n = 4'hF;
  endtask

  task automatic go_wr(logic [7:0] a, logic [3:0] ln);
    load_n = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = 1'b0; lanes_n = ln; addr_ext = a;
  endtask

  task automatic go_rd(logic [7:0] a);
    load_n = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = 1'b1; lanes_n = 4'hF; addr_ext = a;
  endtask

  task automatic drain();
    nop(); din = '0;
    repeat (3) tick();
  endtask

  task automatic pipe_write(logic [7:0] a, logic [3:0] ln, logic [35:0] d);
    go_wr(a, ln); tick();
    nop(); tick();
    din = d; tick();
    din = '0;
  endtask

  task automatic pipe_read_chk(logic [7:0] a, logic [35:0] exp, string tag);
    go_rd(a); tick();
    chk({tag, " R4 not yet driven"}, dout_en, 1'b0);
    nop(); tick();
    chk({tag, " R4 driven"}, dout_en, 1'b1);
    chk({tag, " R4 data"}, dout, exp);
    tick();
    chk({tag, " R4 released"}, dout_en, 1'b0);
  endtask

  task automatic flow_write(logic [7:0] a, logic [3:0] ln, logic [35:0] d);
    go_wr(a, ln); tick();
    nop(); din = d; tick();
    din = '0;
  endtask

  task automatic flow_read_chk(logic [7:0] a, logic [35:0] exp, string tag);
    go_rd(a); tick();
    chk({tag, " R6 driven"}, dout_en, 1'b1);
    chk({tag, " R6 data"}, dout, exp);
    nop(); tick();
    chk({tag, " R6 released"}, dout_en, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; flow_mode = 1'b0; clk_en_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    addr_ext = '0; addr_cont = '0; din = '0;
    nop();
    repeat (3) tick();
    chk("R11 dout_en in reset", dout_en, 1'b0);
    chk("R11 dout in reset", dout, '0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_pipe_basic();
    pipe_write(8'h10, 4'h0, D1);
    pipe_read_chk(8'h10, D1, "R2/R5 write then read");
  endtask

  task automatic t_coherent();
    pipe_write(8'h20, 4'h0, D2);
    go_wr(8'h20, 4'b1010); tick();
    go_rd(8'h20); tick();
    chk("R8 off behind write", dout_en, 1'b0);
    nop(); din = D3; tick();
    chk("R10 pending write forwarded, enable", dout_en, 1'b1);
    chk("R10 pending write forwarded, data", dout, exp_merge(D2, D3, 4'b1010));
    din = '0; tick();
    pipe_read_chk(8'h20, exp_merge(D2, D3, 4'b1010), "R3 lanes 0 and 2");
  endtask

  task automatic t_abort();
    pipe_write(8'h10, 4'hF, JUNK);
    pipe_read_chk(8'h10, D1, "R3 abort");
  endtask

  task automatic t_deselect();
    for (int k = 0; k < 3; k++) begin
      go_wr(8'h10, 4'h0);
      if (k == 0) sel_a_n = 1'b1;
      if (k == 1) sel_b = 1'b0;
      if (k == 2) sel_c_n = 1'b1;
      tick();
      nop(); tick();
      din = JUNK; tick();
      din = '0;
    end
    pipe_read_chk(8'h10, D1, "R1 deselected writes");
    go_rd(8'h10); sel_b = 1'b0; tick();
    nop(); tick();
    chk("R1 deselected read", dout_en, 1'b0);
    tick();
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    go_rd(8'h10); tick();
    nop(); tick();
    chk("R8 dummy read off", dout_en, 1'b0);
    oe_n = 1'b0; #1;
    chk("R8 async enable", dout_en, 1'b1);
    chk("R8 async data", dout, D1);
    tick();
    go_wr(8'h60, 4'h0); tick();
    chk("R8 write cycle 1", dout_en, 1'b0);
    nop(); tick();
    chk("R8 write cycle 2", dout_en, 1'b0);
    din = D7; tick();
    chk("R8 write cycle 3", dout_en, 1'b0);
    din = '0;
    pipe_read_chk(8'h60, D7, "R8 write landed");
  endtask

  task automatic t_stall();
    go_rd(8'h10); tick();
    nop(); tick();
    clk_en_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 read held, enable", dout_en, 1'b1);
      chk("R7 read held, data", dout, D1);
    end
    clk_en_n = 1'b0; tick();
    chk("R7 released after stall", dout_en, 1'b0);
    go_wr(8'h30, 4'h0); tick();
    clk_en_n = 1'b1; nop(); din = JUNK;
    tick(); tick();
    chk("R7 write stalled off", dout_en, 1'b0);
    clk_en_n = 1'b0; din = '0; tick();
    din = D4; tick();
    din = '0;
    pipe_read_chk(8'h30, D4, "R7 stalled write");
  endtask

  task automatic t_flow();
    drain(); flow_mode = 1'b1; drain();
    flow_write(8'h40, 4'h0, D5);
    flow_read_chk(8'h40, D5, "flow basic");
    go_wr(8'h40, 4'b0111); tick();
    chk("R8 flow write off", dout_en, 1'b0);
    go_rd(8'h40); din = D6; tick();
    chk("R6 back-to-back enable", dout_en, 1'b1);
    chk("R10 flow merge", dout, exp_merge(D5, D6, 4'b0111));
    nop(); din = '0; tick();
  endtask

  task automatic t_continue();
    go_wr(8'h50, 4'h0); tick();
    load_n = 1'b1; addr_cont = 8'h51; lanes_n = 4'h0; wr_n = 1'b1; din = DA; tick();
    nop(); din = DB; tick();
    din = '0;
    go_rd(8'h50); tick();
    chk("R9 first beat", dout, DA);
    load_n = 1'b1; addr_cont = 8'h51; wr_n = 1'b0; tick();
    chk("R9 continue read enable", dout_en, 1'b1);
    chk("R9 continue write/read beat", dout, DB);
    nop(); tick();
    load_n = 1'b1; addr_cont = 8'h50; wr_n = 1'b0; lanes_n = 4'h0; din = JUNK; tick();
    chk("R9 continue after deselect 1", dout_en, 1'b0);
    tick();
    chk("R9 continue after deselect 2", dout_en, 1'b0);
    nop(); din = '0; tick();
    flow_read_chk(8'h50, DA, "R9 no write after deselect");
  endtask

  task automatic t_sleep();
    go_rd(8'h50); tick();
    chk("R12 read on before sleep", dout_en, 1'b1);
    sleep = 1'b1; #1;
    chk("R12 sleep forces off", dout_en, 1'b0);
    go_wr(8'h50, 4'h0); din = JUNK;
    tick(); tick();
    chk("R12 off while asleep", dout_en, 1'b0);
    sleep = 1'b0; nop(); din = '0; tick();
    flow_read_chk(8'h50, DA, "R12 command dropped");
  endtask

  initial begin
    t_reset();
    t_pipe_basic();
    t_coherent();
    t_abort();
    t_deselect();
    t_oe();
    t_stall();
    t_flow();
    t_continue();
    t_sleep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule